// File: doc/BRIEF.md
# Speculative Incoherent Load Verifier

This block sits next to a cache controller and handles the loads that find their tag in the cache but lack the permission needed to use it. Such a coherence miss always starts the ordinary coherence request at once. If the miss-status holding file has a free entry and the confidence counter for the load's program counter is high enough, the block also returns the stale word from the cache in the same cycle. The core can then compute with that word before the coherent copy arrives.

Each outstanding miss occupies one holding entry. The entry keeps the stale word, a flag saying whether it was speculated on, the load PC and the line address. When the coherent fill for an entry arrives, the block compares the two words. It then reports one of three verdicts. A confirm means the speculation was correct. A squash tells the pipeline to discard the load and everything younger. A plain completion is reported for a miss that never speculated.

The confirm and squash verdicts also train a table of saturating counters, indexed by PC. Load PCs whose guesses keep failing stop speculating and wait for the coherent data instead.

Top module: `spec_load_verifier`

## Requirements
- R1: A coherence miss is a valid load whose tag matches (`lk_match`=1) while the line state is invalid (0), or is shared (1) with `ld_atomic`=1. If a holding entry is free, the miss raises `req_valid` in the same cycle. `req_line` carries the load's line address and `req_id` the lowest-numbered free entry.
- R2: A load that is not a coherence miss raises none of `req_valid`, `spec_valid` and `ld_stall`. This covers a tag mismatch, a shared line read without the atomic flag, an exclusive line (2) and a modified line (3).
- R3: When the miss is issued and the counter for the load PC is at 2 or above, `spec_valid` rises in the same cycle and `spec_word` equals `lk_word`.
- R4: When the miss is issued and the counter is below 2, the request still goes out but `spec_valid` stays low.
- R5: A coherence miss that finds every holding entry busy raises `ld_stall` and raises neither `req_valid` nor `spec_valid`.
- R6: A fill on a busy, speculated entry whose word equals the held word produces `done_kind`=1 (confirm) one cycle after the fill. That cycle also carries the entry id, the coherent word, the load PC and the line address. Every issued request receives exactly one verdict.
- R7: A fill on a busy, speculated entry whose word differs from the held word produces `done_kind`=2 (squash) one cycle after the fill. It carries the same fields as R6.
- R8: A fill on a busy entry that did not speculate produces `done_kind`=0 (complete). It performs no compare and leaves the counter unchanged.
- R9: Each counter is 2 bits wide and resets to 2. A confirm increments it and saturates at 3. A squash clears it to 0. The counter is selected by PC bits [`PC_LSB` +: `CONF_IDX_W`], with `PC_LSB`=2.
- R10: A fill naming an entry that is not busy is ignored. No verdict follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load lookup is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the load (128-byte lines by default) |
| ld_atomic | input | 1 | The load is atomic and needs write permission |
| lk_match | input | 1 | The cache tag matched |
| lk_state | input | 2 | Line state: 0 invalid, 1 shared, 2 exclusive, 3 modified |
| lk_word | input | DATA_W | Word currently held in the cache line |
| ld_stall | output | 1 | Coherence miss with no free holding entry |
| spec_valid | output | 1 | The speculative word is being returned |
| spec_word | output | DATA_W | Speculative (possibly stale) word |
| req_valid | output | 1 | Coherence request issued |
| req_id | output | log2(N_ENTRIES) | Holding entry allocated to the request |
| req_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| fill_valid | input | 1 | Coherent word returned |
| fill_id | input | log2(N_ENTRIES) | Entry that the fill completes |
| fill_word | input | DATA_W | Coherent word |
| done_valid | output | 1 | Verdict valid |
| done_kind | output | 2 | 0 complete, 1 confirm, 2 squash |
| done_id | output | log2(N_ENTRIES) | Entry the verdict refers to |
| done_word | output | DATA_W | Coherent word of the finished load |
| done_pc | output | PC_W | PC of the finished load |
| done_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the finished load |

## Verification
The bench builds the block with 4 holding entries, a 16-entry counter table, 32-bit data and PC, and a 32-bit address. The small file lets four outstanding misses fill it, so the stall case and the lowest-free-entry allocation are easy to reach. Separate counters for three PCs let the bench train one counter to saturation, clear another with a squash, and watch a third move from speculating to waiting.

// File: rtl/slv_pkg.sv
package slv_pkg;
   typedef enum logic [1:0] {
      ST_INVALID = 2'd0,
      ST_SHARED  = 2'd1,
      ST_EXCL    = 2'd2,
      ST_DIRTY   = 2'd3
   } line_state_e;

   typedef enum logic [1:0] {
      VD_COMPLETE = 2'd0,
      VD_CONFIRM  = 2'd1,
      VD_SQUASH   = 2'd2
   } verdict_e;
endpackage

// File: rtl/slv_conf_table.sv
module slv_conf_table #(
   parameter int IDX_W  = 6,
   parameter int CNT_W  = 2,
   parameter int THRESH = 2,
   parameter int INIT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_ok,
   input  logic             upd_valid,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_confirm
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int CMAX  = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CMAX);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT);
   localparam logic [CNT_W-1:0] CNT_THR  = CNT_W'(THRESH);

   generate
      if (THRESH > CMAX || INIT > CMAX || THRESH < 1) begin : g_bad_cfg
         $error("slv_conf_table: threshold or initial value out of counter range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CNT_INIT;
      end else if (upd_valid) begin
         if (!upd_confirm)
            cnt_q[upd_idx] <= '0;
         else if (cnt_q[upd_idx] != CNT_MAX)
            cnt_q[upd_idx] <= cnt_q[upd_idx] + 1'b1;
      end
   end

   assign rd_ok = (cnt_q[rd_idx] >= CNT_THR);
endmodule

// File: rtl/slv_hold_file.sv
module slv_hold_file #(
   parameter int N_ENTRIES = 8,
   parameter int DATA_W    = 64,
   parameter int PC_W      = 32,
   parameter int LINE_W    = 33,
   parameter int ID_W      = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic              alloc_spec,
   input  logic [DATA_W-1:0] alloc_word,
   input  logic [PC_W-1:0]   alloc_pc,
   input  logic [LINE_W-1:0] alloc_line,
   output logic              free_any,
   output logic [ID_W-1:0]   free_id,
   input  logic              rel_valid,
   input  logic [ID_W-1:0]   rel_id,
   output logic [N_ENTRIES-1:0] busy,
   input  logic [ID_W-1:0]   rd_id,
   output logic              rd_spec,
   output logic [DATA_W-1:0] rd_word,
   output logic [PC_W-1:0]   rd_pc,
   output logic [LINE_W-1:0] rd_line
);
   logic              spec_arr [N_ENTRIES];
   logic [DATA_W-1:0] word_arr [N_ENTRIES];
   logic [PC_W-1:0]   pc_arr   [N_ENTRIES];
   logic [LINE_W-1:0] line_arr [N_ENTRIES];

   generate
      for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
         logic              v_q;
         logic              s_q;
         logic [DATA_W-1:0] w_q;
         logic [PC_W-1:0]   p_q;
         logic [LINE_W-1:0] l_q;
         logic              take;
         logic              drop;

         assign take = alloc_valid && (free_id == ID_W'(g));
         assign drop = rel_valid && (rel_id == ID_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               s_q <= 1'b0;
               w_q <= '0;
               p_q <= '0;
               l_q <= '0;
            end else if (take) begin
               v_q <= 1'b1;
               s_q <= alloc_spec;
               w_q <= alloc_word;
               p_q <= alloc_pc;
               l_q <= alloc_line;
            end else if (drop) begin
               v_q <= 1'b0;
            end
         end

         assign busy[g]     = v_q;
         assign spec_arr[g] = s_q;
         assign word_arr[g] = w_q;
         assign pc_arr[g]   = p_q;
         assign line_arr[g] = l_q;
      end
   endgenerate

   always_comb begin
      free_any = 1'b0;
      free_id  = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            free_any = 1'b1;
            free_id  = ID_W'(i);
         end
      end
   end

   assign rd_spec = spec_arr[rd_id];
   assign rd_word = word_arr[rd_id];
   assign rd_pc   = pc_arr[rd_id];
   assign rd_line = line_arr[rd_id];
endmodule

// File: rtl/slv_verdict.sv
module slv_verdict
   import slv_pkg::*;
#(
   parameter int ID_W   = 3,
   parameter int DATA_W = 64,
   parameter int PC_W   = 32,
   parameter int LINE_W = 33
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [ID_W-1:0]   fill_id,
   input  logic [DATA_W-1:0] fill_word,
   input  logic              entry_busy,
   input  logic              rd_spec,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [PC_W-1:0]   rd_pc,
   input  logic [LINE_W-1:0] rd_line,
   output logic              rel_valid,
   output logic              upd_valid,
   output logic              upd_confirm,
   output logic              done_valid,
   output logic [1:0]        done_kind,
   output logic [ID_W-1:0]   done_id,
   output logic [DATA_W-1:0] done_word,
   output logic [PC_W-1:0]   done_pc,
   output logic [LINE_W-1:0] done_line
);
   logic     accept;
   logic     same;
   verdict_e kind;

   assign accept      = fill_valid && entry_busy;
   assign same        = (rd_word == fill_word);
   assign rel_valid   = accept;
   assign upd_valid   = accept && rd_spec;
   assign upd_confirm = same;

   always_comb begin
      if (!rd_spec)  kind = VD_COMPLETE;
      else if (same) kind = VD_CONFIRM;
      else           kind = VD_SQUASH;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_valid <= 1'b0;
         done_kind  <= VD_COMPLETE;
         done_id    <= '0;
         done_word  <= '0;
         done_pc    <= '0;
         done_line  <= '0;
      end else begin
         done_valid <= accept;
         if (accept) begin
            done_kind <= kind;
            done_id   <= fill_id;
            done_word <= fill_word;
            done_pc   <= rd_pc;
            done_line <= rd_line;
         end
      end
   end
endmodule

// File: rtl/spec_load_verifier.sv
module spec_load_verifier
   import slv_pkg::*;
#(
   parameter int N_ENTRIES   = 8,
   parameter int DATA_W      = 64,
   parameter int PC_W        = 32,
   parameter int ADDR_W      = 40,
   parameter int LINE_BYTES  = 128,
   parameter int CONF_IDX_W  = 6,
   parameter int CONF_CNT_W  = 2,
   parameter int CONF_THRESH = 2,
   parameter int CONF_INIT   = 2,
   parameter int PC_LSB      = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   ld_valid,
   input  logic [PC_W-1:0]                        ld_pc,
   input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   ld_line,
   input  logic                                   ld_atomic,
   input  logic                                   lk_match,
   input  logic [1:0]                             lk_state,
   input  logic [DATA_W-1:0]                      lk_word,
   output logic                                   ld_stall,
   output logic                                   spec_valid,
   output logic [DATA_W-1:0]                      spec_word,
   output logic                                   req_valid,
   output logic [$clog2(N_ENTRIES)-1:0]           req_id,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   req_line,
   input  logic                                   fill_valid,
   input  logic [$clog2(N_ENTRIES)-1:0]           fill_id,
   input  logic [DATA_W-1:0]                      fill_word,
   output logic                                   done_valid,
   output logic [1:0]                             done_kind,
   output logic [$clog2(N_ENTRIES)-1:0]           done_id,
   output logic [DATA_W-1:0]                      done_word,
   output logic [PC_W-1:0]                        done_pc,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   done_line
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int ID_W   = $clog2(N_ENTRIES);

   generate
      if ((1 << ID_W) != N_ENTRIES || N_ENTRIES < 2) begin : g_bad_entries
         $error("spec_load_verifier: N_ENTRIES must be a power of two, at least 2");
      end
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
         $error("spec_load_verifier: LINE_BYTES must be a power of two");
      end
      if (PC_LSB + CONF_IDX_W > PC_W) begin : g_bad_idx
         $error("spec_load_verifier: confidence index exceeds PC width");
      end
   endgenerate

   line_state_e st;
   logic        coh_miss;
   logic        free_any;
   logic [ID_W-1:0] free_id;
   logic [N_ENTRIES-1:0] busy;
   logic        conf_ok;
   logic        rd_spec;
   logic [DATA_W-1:0] rd_word;
   logic [PC_W-1:0]   rd_pc;
   logic [LINE_W-1:0] rd_line;
   logic        rel_valid;
   logic        upd_valid;
   logic        upd_confirm;

   assign st       = line_state_e'(lk_state);
   assign coh_miss = ld_valid && lk_match &&
                     ((st == ST_INVALID) || ((st == ST_SHARED) && ld_atomic));

   assign ld_stall   = coh_miss && !free_any;
   assign req_valid  = coh_miss && free_any;
   assign req_id     = free_id;
   assign req_line   = ld_line;
   assign spec_valid = req_valid && conf_ok;
   assign spec_word  = lk_word;

   slv_conf_table #(
      .IDX_W  (CONF_IDX_W),
      .CNT_W  (CONF_CNT_W),
      .THRESH (CONF_THRESH),
      .INIT   (CONF_INIT)
   ) u_conf (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_idx      (ld_pc[PC_LSB +: CONF_IDX_W]),
      .rd_ok       (conf_ok),
      .upd_valid   (upd_valid),
      .upd_idx     (rd_pc[PC_LSB +: CONF_IDX_W]),
      .upd_confirm (upd_confirm)
   );

   slv_hold_file #(
      .N_ENTRIES (N_ENTRIES),
      .DATA_W    (DATA_W),
      .PC_W      (PC_W),
      .LINE_W    (LINE_W),
      .ID_W      (ID_W)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_valid (req_valid),
      .alloc_spec  (spec_valid),
      .alloc_word  (lk_word),
      .alloc_pc    (ld_pc),
      .alloc_line  (ld_line),
      .free_any    (free_any),
      .free_id     (free_id),
      .rel_valid   (rel_valid),
      .rel_id      (fill_id),
      .busy        (busy),
      .rd_id       (fill_id),
      .rd_spec     (rd_spec),
      .rd_word     (rd_word),
      .rd_pc       (rd_pc),
      .rd_line     (rd_line)
   );

   slv_verdict #(
      .ID_W   (ID_W),
      .DATA_W (DATA_W),
      .PC_W   (PC_W),
      .LINE_W (LINE_W)
   ) u_verdict (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_valid  (fill_valid),
      .fill_id     (fill_id),
      .fill_word   (fill_word),
      .entry_busy  (busy[fill_id]),
      .rd_spec     (rd_spec),
      .rd_word     (rd_word),
      .rd_pc       (rd_pc),
      .rd_line     (rd_line),
      .rel_valid   (rel_valid),
      .upd_valid   (upd_valid),
      .upd_confirm (upd_confirm),
      .done_valid  (done_valid),
      .done_kind   (done_kind),
      .done_id     (done_id),
      .done_word   (done_word),
      .done_pc     (done_pc),
      .done_line   (done_line)
   );
endmodule

// File: rtl/slv_checker.sv
module slv_checker #(
   parameter int N_ENTRIES = 8,
   parameter int ID_W      = $clog2(N_ENTRIES)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ld_valid,
   input logic            ld_atomic,
   input logic            lk_match,
   input logic [1:0]      lk_state,
   input logic            ld_stall,
   input logic            spec_valid,
   input logic            req_valid,
   input logic [ID_W-1:0] req_id,
   input logic            fill_valid,
   input logic [ID_W-1:0] fill_id,
   input logic            done_valid,
   input logic [1:0]      done_kind
);
   logic [N_ENTRIES-1:0] busy_q;
   logic                 fill_ok_q;
   logic                 miss_seen;

   assign miss_seen = ld_valid && lk_match &&
                      (lk_state == 2'd0 || (lk_state == 2'd1 && ld_atomic));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= '0;
         fill_ok_q <= 1'b0;
      end else begin
         fill_ok_q <= fill_valid && busy_q[fill_id];
         if (req_valid) busy_q[req_id] <= 1'b1;
         if (fill_valid && busy_q[fill_id]) busy_q[fill_id] <= 1'b0;
      end
   end

   AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !busy_q[req_id]); // R1
   AST_NO_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_seen |-> (!req_valid && !ld_stall && !spec_valid)); // R2
   AST_SPEC_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      spec_valid |-> req_valid); // R3
   AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stall |-> (!req_valid && !spec_valid && (&busy_q))); // R5
   AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_kind != 2'd3)); // R6
   AST_VERDICT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid == fill_ok_q); // R10
endmodule

bind spec_load_verifier slv_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_valid   (ld_valid),
   .ld_atomic  (ld_atomic),
   .lk_match   (lk_match),
   .lk_state   (lk_state),
   .ld_stall   (ld_stall),
   .spec_valid (spec_valid),
   .req_valid  (req_valid),
   .req_id     (req_id),
   .fill_valid (fill_valid),
   .fill_id    (fill_id),
   .done_valid (done_valid),
   .done_kind  (done_kind)
);

// File: tb/spec_load_verifier_bench.sv
`timescale 1ns/1ps
module spec_load_verifier_bench;
   localparam int N    = 4;
   localparam int DW   = 32;
   localparam int PW   = 32;
   localparam int AW   = 32;
   localparam int LW   = AW - 7;
   localparam int IW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_valid = 1'b0, ld_atomic = 1'b0, lk_match = 1'b0;
   logic [PW-1:0] ld_pc = '0;
   logic [LW-1:0] ld_line = '0;
   logic [1:0]    lk_state = '0;
   logic [DW-1:0] lk_word = '0;
   logic ld_stall, spec_valid, req_valid, done_valid;
   logic [DW-1:0] spec_word, done_word;
   logic [IW-1:0] req_id, done_id;
   logic [LW-1:0] req_line, done_line;
   logic fill_valid = 1'b0;
   logic [IW-1:0] fill_id = '0;
   logic [DW-1:0] fill_word = '0;
   logic [1:0] done_kind;
   logic [PW-1:0] done_pc;

   always #5 clk = ~clk;

   spec_load_verifier #(
      .N_ENTRIES(N), .DATA_W(DW), .PC_W(PW), .ADDR_W(AW), .LINE_BYTES(128),
      .CONF_IDX_W(4), .CONF_CNT_W(2), .CONF_THRESH(2), .CONF_INIT(2), .PC_LSB(2)
   ) u_spec_load_verifier (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_line(ld_line),
      .ld_atomic(ld_atomic), .lk_match(lk_match), .lk_state(lk_state), .lk_word(lk_word),
      .ld_stall(ld_stall), .spec_valid(spec_valid), .spec_word(spec_word),
      .req_valid(req_valid), .req_id(req_id), .req_line(req_line),
      .fill_valid(fill_valid), .fill_id(fill_id), .fill_word(fill_word),
      .done_valid(done_valid), .done_kind(done_kind), .done_id(done_id),
      .done_word(done_word), .done_pc(done_pc), .done_line(done_line)
   );

   typedef struct {
      logic [1:0]    kind;
      int            id;
      logic [DW-1:0] word;
      logic [PW-1:0] pc;
      logic [LW-1:0] line;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   bit            busy_m [N];
   bit            spec_m [N];
   logic [DW-1:0] word_m [N];
   logic [PW-1:0] pc_m   [N];
   logic [LW-1:0] line_m [N];
   int            conf_m [16];

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic do_load(input logic [PW-1:0] pc, input logic [LW-1:0] line,
                          input logic at, input logic mt, input logic [1:0] st,
                          input logic [DW-1:0] w, input string why);
      int fr;
      int ix;
      bit miss, er, es;
      string tg;
      @(negedge clk);
      ld_valid = 1'b1; ld_pc = pc; ld_line = line; ld_atomic = at;
      lk_match = mt; lk_state = st; lk_word = w;
      #1;
      miss = mt && (st == 2'd0 || (st == 2'd1 && at));
      fr = -1;
      for (int i = N - 1; i >= 0; i--) if (!busy_m[i]) fr = i;
      ix = int'((pc >> 2) & 32'hf);
      er = miss && (fr >= 0);
      es = er && (conf_m[ix] >= 2);
      tg = !miss ? "R2" : ((fr < 0) ? "R5" : (es ? "R3" : "R4"));
      chk(tg, {why, " req_valid"}, 64'(req_valid), 64'(er));
      chk(tg, {why, " spec_valid"}, 64'(spec_valid), 64'(es));
      chk(tg, {why, " ld_stall"}, 64'(ld_stall), 64'(miss && fr < 0));
      if (er) begin
         chk("R1", "req_id", 64'(req_id), 64'(fr));
         chk("R1", "req_line", 64'(req_line), 64'(line));
         busy_m[fr] = 1; spec_m[fr] = es; word_m[fr] = w;
         pc_m[fr] = pc; line_m[fr] = line;
      end
      if (es) chk("R3", "spec_word", 64'(spec_word), 64'(w));
      @(posedge clk);
      #1 ld_valid = 1'b0;
   endtask

   task automatic do_fill(input int id, input logic [DW-1:0] w);
      exp_t e;
      int ix;
      @(negedge clk);
      fill_valid = 1'b1; fill_id = IW'(id); fill_word = w;
      if (busy_m[id]) begin
         e.id = id; e.word = w; e.pc = pc_m[id]; e.line = line_m[id];
         ix = int'((pc_m[id] >> 2) & 32'hf);
         if (!spec_m[id]) e.kind = 2'd0;
         else if (w == word_m[id]) begin
            e.kind = 2'd1;
            if (conf_m[ix] < 3) conf_m[ix]++;
         end else begin
            e.kind = 2'd2;
            conf_m[ix] = 0;
         end
         q.push_back(e);
         busy_m[id] = 0;
      end
      @(posedge clk);
      #1 fill_valid = 1'b0;
   endtask

   // monitor: pops expected verdicts as the design produces them
   always @(negedge clk) begin
      if (rst_n && done_valid) begin
         if (q.size() == 0) begin
            chk("R10", "unexpected verdict", 64'(done_valid), 64'd0);
         end else begin
            exp_t e;
            string tg;
            e = q.pop_front();
            tg = (e.kind == 2'd0) ? "R8" : ((e.kind == 2'd1) ? "R6" : "R7");
            chk(tg, "done_kind", 64'(done_kind), 64'(e.kind));
            chk(tg, "done_id", 64'(done_id), 64'(e.id));
            chk(tg, "done_word", 64'(done_word), 64'(e.word));
            chk(tg, "done_pc", 64'(done_pc), 64'(e.pc));
            chk(tg, "done_line", 64'(done_line), 64'(e.line));
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   localparam logic [PW-1:0] PA = 32'h100;
   localparam logic [PW-1:0] PB = 32'h104;
   localparam logic [PW-1:0] PC = 32'h108;

   initial begin
      for (int i = 0; i < 16; i++) conf_m[i] = 2;
      for (int i = 0; i < N; i++) busy_m[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "reset req_valid", 64'(req_valid), 64'd0);
      chk("R2", "reset spec_valid", 64'(spec_valid), 64'd0);
      chk("R5", "reset ld_stall", 64'(ld_stall), 64'd0);
      chk("R10", "reset done_valid", 64'(done_valid), 64'd0);

      // R2: lookups that are not coherence misses
      do_load(PA, 25'h10, 1'b0, 1'b0, 2'd0, 32'h5, "R2 no-match");
      do_load(PA, 25'h10, 1'b1, 1'b1, 2'd2, 32'h5, "R2 exclusive");
      do_load(PA, 25'h10, 1'b0, 1'b1, 2'd3, 32'h5, "R2 modified");
      do_load(PB, 25'h20, 1'b0, 1'b1, 2'd1, 32'h5, "R2 shared-plain");

      // R1/R3: invalid line and shared atomic both speculate
      do_load(PA, 25'h10, 1'b0, 1'b1, 2'd0, 32'h11, "R3 invalid");
      do_load(PB, 25'h20, 1'b1, 1'b1, 2'd1, 32'h22, "R3 shared-atomic");
      do_fill(0, 32'h11);                 // R6 confirm, counter A -> 3
      do_fill(1, 32'h99);                 // R7 squash, counter B -> 0

      // R4/R8: low confidence waits, plain completion keeps counter at 0
      do_load(PB, 25'h21, 1'b0, 1'b1, 2'd0, 32'h33, "R4 low-conf");
      do_fill(0, 32'h44);
      do_fill(2, 32'h55);                 // R10 entry 2 not busy
      @(negedge clk);
      chk("R10", "done after idle fill", 64'(done_valid), 64'd0);
      do_load(PB, 25'h22, 1'b0, 1'b1, 2'd0, 32'h66, "R9 still-zero");
      do_fill(0, 32'h66);

      // R9: saturation at 3, no wrap to zero
      do_load(PA, 25'h11, 1'b0, 1'b1, 2'd0, 32'h77, "R9 at-three");
      do_fill(0, 32'h77);
      do_load(PA, 25'h12, 1'b0, 1'b1, 2'd0, 32'h78, "R9 saturated");
      do_fill(0, 32'h78);

      // R5: fill the file, then one more miss stalls
      for (int i = 0; i < N; i++)
         do_load(PC, LW'(25'h30 + i), 1'b0, 1'b1, 2'd0, 32'hA0 + i, "R1 fill-file");
      do_load(PC, 25'h40, 1'b0, 1'b1, 2'd0, 32'hBB, "R5 full");
      do_fill(2, 32'hDEAD);               // R7 squash, counter C -> 0
      do_load(PC, 25'h41, 1'b0, 1'b1, 2'd0, 32'hCC, "R9 after-squash");
      do_fill(0, 32'hA0);
      do_fill(1, 32'hA1);
      do_fill(3, 32'hA3);
      do_fill(2, 32'hCD);

      repeat (3) @(negedge clk);
      chk("R6", "verdicts outstanding", 64'(q.size()), 64'd0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule